// File: doc/BRIEF.md
# Debug Monitor Entry Controller

This block decides, at the moment the chip leaves reset, whether a small microcontroller starts in its serial debug monitor mode or runs normally. It looks at three digital flags: the high test voltage sensed on the interrupt pin, the same voltage sensed on the reset pin, and a flag saying the reset vector is erased. On the first clock after `rst_n` is released it stores which entry condition applied. From then on the flags cannot change that choice. When the erased-vector path is taken, the block also issues one extra internal reset pulse before it goes on.

In monitor mode the block listens on the serial receive line for a fixed number of security bytes. It does not judge their content. Once the last byte arrives, it drives a break on the transmit line (ten bit times at logic 0) and then reports that it is ready for a command. Bit timing comes from a bus tick, which is the input clock divided by `CLK_DIV`, and a bit lasts `BIT_BUS_CYC` bus ticks. With the defaults, a 9.8304 MHz input gives 9600 baud.

The block also drives the watchdog disable. Its policy depends on the stored entry condition.

Top module: `mon_entry_ctrl`

## Requirements
- R1: The entry condition is captured on the first clock after `rst_n` rises. Later changes on `hv_irq`, `hv_rst` or `blank_vec` leave `entry_condition` and `monitor_active` unchanged.
- R2: Encoding of `entry_condition`: 2'b01 when `hv_irq` was high at capture, which takes priority; 2'b10 when only `blank_vec` was high; 2'b00 otherwise. `monitor_active` is 1 exactly when the code is not 2'b00.
- R3: In monitor mode the receiver accepts frames of 1 start bit (0), 8 data bits and 1 stop bit (1). One bit time is `CLK_DIV*BIT_BUS_CYC` clocks. Fewer than `SEC_BYTES` (8) accepted bytes produce no break.
- R4: The accepted byte that brings the count to `SEC_BYTES` starts a break: `tx` stays low for 10 bit times. After the break `tx` returns high and `cmd_ready` goes to 1.
- R5: A frame whose stop bit reads 0 is rejected and does not add to the security byte count.
- R6: Erased-vector entry: `reset_out` goes high right after capture and stays high for exactly `EXTRA_CYC` clocks. It is never high for the other entry conditions.
- R7: Erased-vector entry: `cop_disable` is 1 whatever the levels of `hv_irq` and `hv_rst`.
- R8: Test-voltage entry: `cop_disable` follows `hv_irq | hv_rst` live.
- R9: Normal mode (code 2'b00): `cop_disable` is 0, `tx` stays 1, `cmd_ready` stays 0, and received bytes have no effect.
- R10: While `rst_n` is low, the stored mode and the byte count are cleared: `monitor_active`=0, `cop_disable`=0, `reset_out`=0, `cmd_ready`=0 and `tx`=1. A later entry starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the bus tick is this divided by CLK_DIV |
| rst_n | input | 1 | Active-low reset; its release captures the mode |
| blank_vec | input | 1 | Reset vector reads as erased |
| hv_irq | input | 1 | Test voltage detected on the interrupt pin |
| hv_rst | input | 1 | Test voltage detected on the reset pin |
| rx | input | 1 | Serial receive line, idle high |
| tx | output | 1 | Serial transmit line, idle high |
| monitor_active | output | 1 | Monitor mode has been entered |
| entry_condition | output | 2 | Stored entry condition code |
| cop_disable | output | 1 | Holds the watchdog off |
| reset_out | output | 1 | Extra internal reset pulse on erased-vector entry |
| cmd_ready | output | 1 | Break sent; ready for a command |

## Verification
The hardest states to reach are those where the byte count must not move even though the serial line was active. One case is a rejected frame placed just before the last byte. The other is a reset that arrives partway through the security sequence. The bench builds a frame with a low stop bit after seven good bytes and checks that no break follows until one more good byte arrives. It also pulses reset after five bytes, re-enters monitor mode, and shows that seven further bytes are not enough. Random byte values and random flag levels are mixed in, to exercise capture priority and the live watchdog policy.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef enum logic [1:0] {
    ENTRY_NONE   = 2'b00,
    ENTRY_HV_IRQ = 2'b01,
    ENTRY_BLANK  = 2'b10
  } entry_t;

  typedef enum logic [2:0] {
    ST_LATCH,
    ST_XRST,
    ST_SEC,
    ST_BRK,
    ST_READY,
    ST_USER
  } mon_st_t;

  // test voltage on the interrupt pin wins over an erased vector
  function automatic entry_t pick_entry(input logic hv_irq, input logic blank);
    if (hv_irq)     return ENTRY_HV_IRQ;
    else if (blank) return ENTRY_BLANK;
    else            return ENTRY_NONE;
  endfunction

  // watchdog disable policy per stored entry condition
  function automatic logic cop_policy(input entry_t e, input logic hv_irq,
                                      input logic hv_rst);
    case (e)
      ENTRY_BLANK:  return 1'b1;
      ENTRY_HV_IRQ: return hv_irq | hv_rst;
      default:      return 1'b0;
    endcase
  endfunction

  // reload value giving a half-bit wait from the start edge
  function automatic int half_bit_load(input int bus_cyc);
    return (bus_cyc / 2) - 1;
  endfunction

endpackage

// File: rtl/mon_bus_tick.sv
module mon_bus_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == DW'(DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == DW'(DIV - 1));
endmodule

// File: rtl/mon_uart_rx.sv
module mon_uart_rx
  import mon_pkg::*;
#(
  parameter int BIT_BUS_CYC = 256,
  parameter int DATA_BITS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic rx,
  output logic byte_ok,
  output logic frame_err
);
  localparam int CW = (BIT_BUS_CYC > 2) ? $clog2(BIT_BUS_CYC) : 1;
  localparam int BW = $clog2(DATA_BITS + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  rx_st_t        st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic          rx_m, rx_s;
  logic          sample_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
    end
  end

  assign sample_now = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      byte_ok   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_ok   <= 1'b0;
      frame_err <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else if (st == RX_IDLE) begin
        if (!rx_s) begin
          st  <= RX_START;
          cnt <= CW'(half_bit_load(BIT_BUS_CYC));
        end
      end else if (tick && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (sample_now) begin
        cnt <= CW'(BIT_BUS_CYC - 1);
        if (st == RX_START) begin
          if (rx_s) st <= RX_IDLE;
          else begin
            st   <= RX_DATA;
            bidx <= '0;
          end
        end else if (st == RX_DATA) begin
          if (bidx == BW'(DATA_BITS - 1)) st <= RX_STOP;
          bidx <= bidx + 1'b1;
        end else begin
          st <= RX_IDLE;
          if (rx_s) byte_ok   <= 1'b1;
          else      frame_err <= 1'b1;
        end
      end
    end
  end

  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_ok && frame_err)); // R5
endmodule

// File: rtl/mon_break_tx.sv
module mon_break_tx #(
  parameter int BIT_BUS_CYC = 256,
  parameter int BITS        = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic tx,
  output logic done
);
  localparam int CW = (BIT_BUS_CYC > 2) ? $clog2(BIT_BUS_CYC) : 1;
  localparam int BW = $clog2(BITS + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      bidx <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= CW'(BIT_BUS_CYC - 1);
          bidx <= '0;
        end
      end else if (tick) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          cnt <= CW'(BIT_BUS_CYC - 1);
          if (bidx == BW'(BITS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
      end
    end
  end

  assign tx = ~busy;

  AST_BRK_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R4
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int BIT_BUS_CYC = 256,
  parameter int SEC_BYTES   = 8,
  parameter int BREAK_BITS  = 10,
  parameter int EXTRA_CYC   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blank_vec,
  input  logic       hv_irq,
  input  logic       hv_rst,
  input  logic       rx,
  output logic       tx,
  output logic       monitor_active,
  output logic [1:0] entry_condition,
  output logic       cop_disable,
  output logic       reset_out,
  output logic       cmd_ready
);
  localparam int SCW = $clog2(SEC_BYTES + 1);
  localparam int XCW = $clog2(EXTRA_CYC + 1);

  mon_st_t        state;
  entry_t         entry;
  entry_t         entry_pick;
  logic [SCW-1:0] sec_cnt;
  logic [XCW-1:0] xcnt;

  logic bus_tick;
  logic rx_byte_ok, rx_frame_err;
  logic sec_last, brk_start, brk_done;

  mon_bus_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(bus_tick)
  );

  mon_uart_rx #(.BIT_BUS_CYC(BIT_BUS_CYC), .DATA_BITS(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(bus_tick), .en(state == ST_SEC),
    .rx(rx), .byte_ok(rx_byte_ok), .frame_err(rx_frame_err)
  );

  mon_break_tx #(.BIT_BUS_CYC(BIT_BUS_CYC), .BITS(BREAK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(bus_tick), .start(brk_start),
    .tx(tx), .done(brk_done)
  );

  assign entry_pick = pick_entry(hv_irq, blank_vec);
  assign sec_last   = (sec_cnt == SCW'(SEC_BYTES - 1));
  assign brk_start  = (state == ST_SEC) && rx_byte_ok && sec_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_LATCH;
      entry   <= ENTRY_NONE;
      sec_cnt <= '0;
      xcnt    <= '0;
    end else begin
      case (state)
        ST_LATCH: begin
          entry <= entry_pick;
          case (entry_pick)
            ENTRY_BLANK:  state <= ST_XRST;
            ENTRY_HV_IRQ: state <= ST_SEC;
            default:      state <= ST_USER;
          endcase
        end
        ST_XRST: begin
          if (xcnt == XCW'(EXTRA_CYC - 1)) state <= ST_SEC;
          xcnt <= xcnt + 1'b1;
        end
        ST_SEC: begin
          if (rx_byte_ok) begin
            if (sec_last) begin
              state   <= ST_BRK;
              sec_cnt <= '0;
            end else begin
              sec_cnt <= sec_cnt + 1'b1;
            end
          end
        end
        ST_BRK: if (brk_done) state <= ST_READY;
        default: ;
      endcase
    end
  end

  assign monitor_active  = (entry != ENTRY_NONE);
  assign entry_condition = entry;
  assign cop_disable     = cop_policy(entry, hv_irq, hv_rst);
  assign reset_out       = (state == ST_XRST);
  assign cmd_ready       = (state == ST_READY);

  AST_ENTRY_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_LATCH) |=> $stable(entry)); // R1
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_cnt <= SCW'(SEC_BYTES - 1)); // R3
  AST_BREAK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx) |-> $past(rx_byte_ok)); // R4
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> tx); // R4
  AST_FRAME_NOCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |=> $stable(sec_cnt)); // R5
  AST_XRST_BLANK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reset_out |-> (entry == ENTRY_BLANK)); // R6
  AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_USER) |-> (tx && !cop_disable && !cmd_ready)); // R9
endmodule

// File: tb/sim_mon_entry_ctrl.sv
`timescale 1ns/1ps
module sim_mon_entry_ctrl;
  localparam int CLK_DIV = 4;
  localparam int BIT_BUS = 4;
  localparam int EXTRA   = 6;
  localparam int BITCLK  = CLK_DIV * BIT_BUS;
  localparam int BRK_LEN = 10 * BITCLK;

  logic clk = 1'b0, rst_n = 1'b0;
  logic blank_vec = 1'b0, hv_irq = 1'b0, hv_rst = 1'b0, rx = 1'b1;
  logic tx, monitor_active, cop_disable, reset_out, cmd_ready;
  logic [1:0] entry_condition;

  int checks = 0, fails = 0;
  int run = 0, last_run = 0, brk_seen = 0, xr_len = 0;

  always #4 clk = ~clk;

  mon_entry_ctrl #(.CLK_DIV(CLK_DIV), .BIT_BUS_CYC(BIT_BUS), .SEC_BYTES(8),
                   .BREAK_BITS(10), .EXTRA_CYC(EXTRA)) u0 (
    .clk(clk), .rst_n(rst_n), .blank_vec(blank_vec), .hv_irq(hv_irq),
    .hv_rst(hv_rst), .rx(rx), .tx(tx), .monitor_active(monitor_active),
    .entry_condition(entry_condition), .cop_disable(cop_disable),
    .reset_out(reset_out), .cmd_ready(cmd_ready)
  );

  // line and pulse observers
  always @(negedge clk) begin
    if (tx === 1'b0) run = run + 1;
    else begin
      if (run > 0) begin
        brk_seen = brk_seen + 1;
        last_run = run;
      end
      run = 0;
    end
    if (!rst_n) xr_len = 0;
    else if (reset_out) xr_len = xr_len + 1;
  end

  function automatic int exp_entry(input logic h, input logic b);
    return h ? 1 : (b ? 2 : 0);
  endfunction

  function automatic int exp_cop(input int e, input logic h, input logic r);
    if (e == 2) return 1;
    if (e == 1) return int'(h | r);
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act,
                         input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic do_reset(input logic h, input logic b, input logic r);
    @(negedge clk);
    rst_n = 1'b0; hv_irq = h; blank_vec = b; hv_rst = r; rx = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic stop_bit);
    rx = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    rx = stop_bit;
    repeat (BITCLK) @(negedge clk);
    rx = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
  endtask

  task automatic send_n(input int n);
    for (int i = 0; i < n; i++) send_byte(8'($urandom), 1'b1);
  endtask

  task automatic wait_break_end();
    repeat (BRK_LEN + 4 * BITCLK) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int b0, ent;
    logic h, bl, r;
    void'($urandom(32'd1234));

    // R10: reset state
    hv_irq = 1'b1; blank_vec = 1'b1; hv_rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "monitor_active in reset", int'(monitor_active), 0);
    chk("R10", "cop_disable in reset", int'(cop_disable), 0);
    chk("R10", "tx/reset_out/cmd_ready in reset",
        int'({tx, reset_out, cmd_ready}), 4);

    // R1 R2 R8: test-voltage entry
    do_reset(1'b1, 1'($urandom), 1'b0);
    chk("R2", "entry code hv", int'(entry_condition), 1);
    chk("R2", "monitor_active hv", int'(monitor_active), 1);
    chk("R6", "no extra reset hv", xr_len, 0);
    for (int k = 0; k < 6; k++) begin
      h = 1'($urandom); bl = 1'($urandom); r = 1'($urandom);
      hv_irq = h; blank_vec = bl; hv_rst = r;
      @(negedge clk);
      chk("R1", "entry kept after pin change", int'(entry_condition), 1);
      chk("R8", "cop follows pins", int'(cop_disable), exp_cop(1, h, r));
    end
    hv_irq = 1'b0; hv_rst = 1'b0;
    b0 = brk_seen;
    send_n(7);
    chk("R3", "no break after 7 bytes", brk_seen - b0, 0);
    send_n(1);
    wait_break_end();
    chk("R4", "one break after 8th byte", brk_seen - b0, 1);
    chk_rng("R4", "break length clocks", last_run, BRK_LEN - 8, BRK_LEN + 4);
    chk("R4", "cmd_ready and tx idle", int'({cmd_ready, tx}), 3);

    // R6 R7 R5: erased-vector entry
    do_reset(1'b0, 1'b1, 1'($urandom));
    chk("R2", "entry code blank", int'(entry_condition), 2);
    repeat (EXTRA + 4) @(negedge clk);
    chk("R6", "extra reset length", xr_len, EXTRA);
    for (int k = 0; k < 4; k++) begin
      h = 1'($urandom); r = 1'($urandom);
      hv_irq = h; hv_rst = r; blank_vec = 1'($urandom);
      @(negedge clk);
      chk("R7", "cop held on blank entry", int'(cop_disable), 1);
      chk("R1", "entry kept blank", int'(entry_condition), 2);
    end
    b0 = brk_seen;
    send_n(7);
    send_byte(8'hA5, 1'b0);
    repeat (4 * BITCLK) @(negedge clk);
    chk("R5", "framing error not counted", brk_seen - b0, 0);
    send_n(1);
    wait_break_end();
    chk("R5", "break after good 8th byte", brk_seen - b0, 1);
    chk("R4", "cmd_ready after blank flow", int'(cmd_ready), 1);

    // R9: normal mode
    do_reset(1'b0, 1'b0, 1'b0);
    chk("R2", "entry code none", int'(entry_condition), 0);
    chk("R9", "monitor inactive", int'(monitor_active), 0);
    b0 = brk_seen;
    hv_irq = 1'b1; hv_rst = 1'b1; blank_vec = 1'b1;
    send_n(9);
    chk("R9", "no break in normal mode", brk_seen - b0, 0);
    chk("R9", "cop off in normal mode", int'(cop_disable), 0);
    chk("R9", "cmd_ready off in normal mode", int'(cmd_ready), 0);

    // R10: reset partway through the security bytes
    do_reset(1'b1, 1'b0, 1'b0);
    hv_irq = 1'b0;
    send_n(5);
    do_reset(1'b1, 1'b0, 1'b0);
    hv_irq = 1'b0;
    b0 = brk_seen;
    send_n(7);
    chk("R10", "count cleared by reset", brk_seen - b0, 0);
    send_n(1);
    wait_break_end();
    chk("R10", "break after fresh 8 bytes", brk_seen - b0, 1);

    // R2: random capture levels
    for (int k = 0; k < 6; k++) begin
      h = 1'($urandom); bl = 1'($urandom); r = 1'($urandom);
      do_reset(h, bl, r);
      ent = exp_entry(h, bl);
      chk("R2", "random entry code", int'(entry_condition), ent);
      chk("R2", "random monitor_active", int'(monitor_active), int'(ent != 0));
      chk("R8", "random cop", int'(cop_disable), exp_cop(ent, h, r));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule